// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block supplies the steering and interlock decisions for a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory and writeback. Register operands are read in the second stage and results are written back only in the fifth. Instructions can therefore depend on values that have been computed but not yet written. The block compares the source register indices of the instructions in decode and execute with the destination indices held in the two later stage registers. From that comparison it picks where each ALU operand comes from: the register file, the execute/memory stage register, or the memory/writeback stage register.

A loaded value appears only at the end of the memory stage. An instruction that uses it in the very next slot therefore cannot be served by bypassing. For that case the block holds the program counter and the fetch/decode register for one cycle and turns the instruction entering execute into a bubble. A store whose data register is the destination of the load just ahead of it is not stalled. The block remembers the store's data index for one cycle and steers the loaded value from the memory/writeback register into the store-data path while the store is in the memory stage. Register 0 is hard-wired to zero, so the block never forwards a write to it. Writes always happen in the same stage, so no write-after-read or write-after-write checks are made.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: Each ALU operand select is 2 bits: 00 = register file, 10 = execute/memory register, 01 = memory/writeback register. The select is 10 when the execute-stage source index equals the execute/memory destination and that stage has its write enable set.
- R2: When the execute/memory stage does not supply an operand, the select is 01 if the source index equals the memory/writeback destination and that stage has its write enable set. Otherwise the select is 00.
- R3: When both later stages match the same source index, the execute/memory stage (the younger producer) wins and the select is 10.
- R4: A destination index of 0 is never forwarded, to an operand or to store data, and never causes a load-use stall.
- R5: A stage whose write enable is clear never supplies a forwarded operand.
- R6: When the execute stage holds a load with write enable set and a nonzero destination, and the decode stage uses that register as an enabled source, then pc_hold, ifid_hold and idex_bubble are all 1 in that cycle. A source whose use flag is clear does not cause a stall.
- R7: A store in decode whose only match with the load in execute is its data source (rs2) does not stall. If its address source (rs1) matches, it stalls.
- R8: store_data_fwd is 1 exactly when the instruction in execute in the previous cycle was a store, the memory/writeback stage now holds a load with write enable set, and that load's nonzero destination equals the store's data index.
- R9: A stall is never raised in two consecutive cycles, so each load-use case inserts exactly one bubble.
- R10: While the execute/memory stage holds a load, it never supplies an ALU operand (its value is only an address).
- R11: After a synchronous active-low reset, with all inputs idle, both selects are 00 and all stall and bypass outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | 5 | Decode-stage first source index |
| id_rs2 | input | 5 | Decode-stage second source index |
| id_use_rs1 | input | 1 | Decode instruction reads first source |
| id_use_rs2 | input | 1 | Decode instruction reads second source |
| id_is_store | input | 1 | Decode instruction is a store (rs2 is store data) |
| ex_rs1 | input | 5 | Execute-stage first source index |
| ex_rs2 | input | 5 | Execute-stage second source index |
| ex_rd | input | 5 | Execute-stage destination index |
| ex_we | input | 1 | Execute-stage register-write enable |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_is_store | input | 1 | Execute-stage instruction is a store |
| exm_rd | input | 5 | Execute/memory register destination index |
| exm_we | input | 1 | Execute/memory register write enable |
| exm_is_load | input | 1 | Execute/memory register holds a load |
| mwb_rd | input | 5 | Memory/writeback register destination index |
| mwb_we | input | 1 | Memory/writeback register write enable |
| mwb_is_load | input | 1 | Memory/writeback register holds a load |
| fwd_sel_a | output | 2 | First ALU operand source select |
| fwd_sel_b | output | 2 | Second ALU operand source select |
| store_data_fwd | output | 1 | Steer loaded value into memory-stage store data |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Clear control fields entering execute |

## Verification
Operand bypass and the load-use interlock look at different stages, so they can fire in the same cycle. The bench provokes this with a load in execute that the decode instruction needs, while an older ALU result in the execute/memory register feeds the execute-stage operand. It expects select 10 together with an asserted stall. The store-data bypass is also driven in a cycle where a new load-use stall begins. Every output is compared against hand-derived values for each cycle. Held inputs after a stall show that the second cycle carries no stall.

// File: rtl/fwd_pkg.sv
// Shared types for the bypass and interlock controller.
// Assumes 2-bit operand select codes decoded by the datapath muxes.
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MWB = 2'b01,
        SEL_EXM = 2'b10
    } opnd_sel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
// Chooses the source of one ALU operand in the execute stage.
// Assumes the execute/memory value of a load is an address, not data,
// so such a stage is never a bypass source.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] exm_rd,
    input  logic             exm_we,
    input  logic             exm_is_load,
    input  logic [IDX_W-1:0] mwb_rd,
    input  logic             mwb_we,
    output opnd_sel_e        sel
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic exm_hit;
    logic mwb_hit;

    // Match against each producing stage.
    always_comb begin
        exm_hit = exm_we && !exm_is_load && (exm_rd != ZERO_IDX) && (exm_rd == src_idx);
        mwb_hit = mwb_we && (mwb_rd != ZERO_IDX) && (mwb_rd == src_idx);
    end

    // Younger producer first, then older, then register file.
    always_comb begin
        if (exm_hit)      sel = SEL_EXM;
        else if (mwb_hit) sel = SEL_MWB;
        else              sel = SEL_RF;
    end

    AST_NO_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_RF) |-> (src_idx != ZERO_IDX)); // R4
    AST_EXM_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_EXM) |-> (!exm_is_load && exm_we)); // R10
    AST_MWB_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MWB) |-> (mwb_we && mwb_rd == src_idx)); // R5
    AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_we && !exm_is_load && exm_rd == src_idx && src_idx != ZERO_IDX) |-> (sel == SEL_EXM)); // R3
endmodule

// File: rtl/load_use_detect.sv
// Detects a decode instruction that needs the result of a load now in
// execute, and requests a one-cycle freeze of fetch/decode plus a bubble.
// Assumes a store's rs2 is data and is served later by the memory-stage
// bypass, so it does not stall.
module load_use_detect #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] id_rs1,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_is_load,
    output logic             stall
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic addr_hit;
    logic data_hit;
    logic need_stall;
    logic stall_q;

    // Compare decode sources with the load destination.
    always_comb begin
        addr_hit   = id_use_rs1 && (id_rs1 == ex_rd);
        data_hit   = id_use_rs2 && (id_rs2 == ex_rd) && !id_is_store;
        need_stall = ex_is_load && ex_we && (ex_rd != ZERO_IDX) && (addr_hit || data_hit);
        stall      = need_stall && !stall_q;
    end

    // Remember the previous stall so one hazard yields one bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= stall;
    end

    AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R9
    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_is_load && ex_we && ex_rd != ZERO_IDX)); // R6
    AST_STORE_DATA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_store && !(id_use_rs1 && id_rs1 == ex_rd)) |-> !stall); // R7
endmodule

// File: rtl/store_data_bypass.sv
// Carries a store's data index from execute into memory and flags when
// the load one stage ahead must feed the store-data path.
// Assumes the execute-to-memory pipeline register always advances.
module store_data_bypass #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_is_store,
    input  logic [IDX_W-1:0] ex_rs2,
    input  logic [IDX_W-1:0] mwb_rd,
    input  logic             mwb_we,
    input  logic             mwb_is_load,
    output logic             sd_fwd
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic             mem_store_q;
    logic [IDX_W-1:0] mem_data_idx_q;

    // Track the store now moving into the memory stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_store_q    <= 1'b0;
            mem_data_idx_q <= '0;
        end else begin
            mem_store_q    <= ex_is_store;
            mem_data_idx_q <= ex_rs2;
        end
    end

    // Steer the loaded word when it is the store's data register.
    always_comb begin
        sd_fwd = mem_store_q && mwb_is_load && mwb_we
                 && (mwb_rd != ZERO_IDX) && (mwb_rd == mem_data_idx_q);
    end

    AST_SD_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_fwd |-> $past(ex_is_store)); // R8
    AST_SD_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sd_fwd |-> (mwb_is_load && mwb_we && mwb_rd != ZERO_IDX)); // R4
endmodule

// File: rtl/fwd_hazard_ctrl.sv
// Top of the bypass and interlock controller for a five-stage in-order
// integer pipeline. Assumes reads in stage 2 and writes in stage 5 only,
// so no write-after-read or write-after-write checks are needed.
module fwd_hazard_ctrl
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] id_rs1,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic [IDX_W-1:0] ex_rs1,
    input  logic [IDX_W-1:0] ex_rs2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_is_load,
    input  logic             ex_is_store,
    input  logic [IDX_W-1:0] exm_rd,
    input  logic             exm_we,
    input  logic             exm_is_load,
    input  logic [IDX_W-1:0] mwb_rd,
    input  logic             mwb_we,
    input  logic             mwb_is_load,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             store_data_fwd,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);
    localparam int NUM_OPND = 2;

    logic [IDX_W-1:0] ex_src [NUM_OPND];
    opnd_sel_e        opnd_sel [NUM_OPND];
    logic             stall;

    // Gather execute-stage sources for the operand selectors.
    always_comb begin
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    generate
        for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
            fwd_operand_sel #(.IDX_W(IDX_W)) sel_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .src_idx     (ex_src[g]),
                .exm_rd      (exm_rd),
                .exm_we      (exm_we),
                .exm_is_load (exm_is_load),
                .mwb_rd      (mwb_rd),
                .mwb_we      (mwb_we),
                .sel         (opnd_sel[g])
            );
        end
    endgenerate

    load_use_detect #(.IDX_W(IDX_W)) lud_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_use_rs1  (id_use_rs1),
        .id_use_rs2  (id_use_rs2),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_we       (ex_we),
        .ex_is_load  (ex_is_load),
        .stall       (stall)
    );

    store_data_bypass #(.IDX_W(IDX_W)) sdb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex_is_store (ex_is_store),
        .ex_rs2      (ex_rs2),
        .mwb_rd      (mwb_rd),
        .mwb_we      (mwb_we),
        .mwb_is_load (mwb_is_load),
        .sd_fwd      (store_data_fwd)
    );

    // Drive the pipeline controls from the shared stall decision.
    always_comb begin
        fwd_sel_a   = opnd_sel[0];
        fwd_sel_b   = opnd_sel[1];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end
endmodule

// File: tb/fwd_hazard_ctrl_tb_top.sv
module fwd_hazard_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       sd;
        logic       st;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mwb_rd;
    logic id_use_rs1, id_use_rs2, id_is_store, ex_we, ex_is_load, ex_is_store;
    logic exm_we, exm_is_load, mwb_we, mwb_is_load;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic store_data_fwd, pc_hold, ifid_hold, idex_bubble;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_hazard_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1),
        .id_use_rs2(id_use_rs2), .id_is_store(id_is_store),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_is_load(ex_is_load), .ex_is_store(ex_is_store),
        .exm_rd(exm_rd), .exm_we(exm_we), .exm_is_load(exm_is_load),
        .mwb_rd(mwb_rd), .mwb_we(mwb_we), .mwb_is_load(mwb_is_load),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .store_data_fwd(store_data_fwd), .pc_hold(pc_hold),
        .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic idle_inputs();
        id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0; id_is_store = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_we = 0; ex_is_load = 0; ex_is_store = 0;
        exm_rd = 0; exm_we = 0; exm_is_load = 0;
        mwb_rd = 0; mwb_we = 0; mwb_is_load = 0;
    endtask

    // Driver: start a new cycle with idle inputs.
    task automatic next_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    // Driver: push the expected outputs for the current cycle.
    task automatic expect_out(logic [1:0] a, logic [1:0] b, logic sd, logic st, string tag);
        exp_t e;
        e.a = a; e.b = b; e.sd = sd; e.st = st; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare a quarter period after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (fwd_sel_a !== e.a || fwd_sel_b !== e.b || store_data_fwd !== e.sd ||
                    pc_hold !== e.st || ifid_hold !== e.st || idex_bubble !== e.st) begin
                    errors++;
                    $display("FAIL %s: got a=%b b=%b sd=%b hold=%b%b%b expected a=%b b=%b sd=%b stall=%b",
                             e.tag, fwd_sel_a, fwd_sel_b, store_data_fwd,
                             pc_hold, ifid_hold, idex_bubble, e.a, e.b, e.sd, e.st);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        // R11: reset state
        repeat (2) @(negedge clk);
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R11 in reset");
        next_cycle(); rst_n = 1'b1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R11 after reset");

        // R1: execute/memory bypass on operand a
        next_cycle(); ex_rs1 = 3; exm_rd = 3; exm_we = 1;
        expect_out(2'b10, 2'b00, 1'b0, 1'b0, "R1 exm to a");
        // R2: memory/writeback bypass on operand b
        next_cycle(); ex_rs2 = 4; mwb_rd = 4; mwb_we = 1;
        expect_out(2'b00, 2'b01, 1'b0, 1'b0, "R2 mwb to b");
        // R3: both stages match, younger wins
        next_cycle(); ex_rs1 = 5; ex_rs2 = 5; exm_rd = 5; exm_we = 1; mwb_rd = 5; mwb_we = 1;
        expect_out(2'b10, 2'b10, 1'b0, 1'b0, "R3 priority");
        // R4: register 0 never forwarded
        next_cycle(); exm_we = 1; mwb_we = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R4 zero index");
        // R5: write enable clear
        next_cycle(); ex_rs1 = 6; ex_rs2 = 6; exm_rd = 6; mwb_rd = 6;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R5 no enables");
        next_cycle(); ex_rs1 = 6; exm_rd = 6; mwb_rd = 6; mwb_we = 1;
        expect_out(2'b01, 2'b00, 1'b0, 1'b0, "R5 exm disabled");
        // R10: load in execute/memory falls through
        next_cycle(); ex_rs1 = 7; exm_rd = 7; exm_we = 1; exm_is_load = 1; mwb_rd = 7; mwb_we = 1;
        expect_out(2'b01, 2'b00, 1'b0, 1'b0, "R10 exm load");

        // R6: load-use stall on rs1
        next_cycle(); ex_rd = 8; ex_we = 1; ex_is_load = 1; id_rs1 = 8; id_use_rs1 = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b1, "R6 rs1 stall");
        // R9: held inputs, second cycle carries no stall
        next_cycle(); ex_rd = 8; ex_we = 1; ex_is_load = 1; id_rs1 = 8; id_use_rs1 = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R9 single bubble");
        next_cycle(); ex_rd = 8; ex_we = 1; ex_is_load = 1; id_rs2 = 8; id_use_rs2 = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b1, "R6 rs2 stall");
        next_cycle();
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R9 idle after");
        // R6: use flag clear
        next_cycle(); ex_rd = 8; ex_we = 1; ex_is_load = 1; id_rs1 = 8;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R6 unused source");
        // R4: load to register 0
        next_cycle(); ex_we = 1; ex_is_load = 1; id_use_rs1 = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R4 load x0");
        // R7: store data only, no stall
        next_cycle(); ex_rd = 9; ex_we = 1; ex_is_load = 1;
        id_is_store = 1; id_rs2 = 9; id_use_rs2 = 1; id_rs1 = 2; id_use_rs1 = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R7 store data");
        next_cycle(); ex_rd = 9; ex_we = 1; ex_is_load = 1;
        id_is_store = 1; id_rs2 = 9; id_use_rs2 = 1; id_rs1 = 9; id_use_rs1 = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b1, "R7 store address");

        // R8: store then load-to-store bypass
        next_cycle(); ex_is_store = 1; ex_rs2 = 10;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R8 store in ex");
        next_cycle(); mwb_rd = 10; mwb_we = 1; mwb_is_load = 1;
        expect_out(2'b00, 2'b00, 1'b1, 1'b0, "R8 load to store");
        next_cycle(); ex_is_store = 1; ex_rs2 = 11;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R8 store 2");
        next_cycle(); mwb_rd = 11; mwb_we = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R8 not a load");
        next_cycle(); ex_rs2 = 12;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R8 no store");
        next_cycle(); mwb_rd = 12; mwb_we = 1; mwb_is_load = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R8 not after store");
        next_cycle(); ex_is_store = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R4 store x0");
        next_cycle(); mwb_we = 1; mwb_is_load = 1;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R4 no sd for x0");

        // Concurrent: operand bypass together with load-use stall
        next_cycle(); ex_rs1 = 13; exm_rd = 13; exm_we = 1;
        ex_rd = 14; ex_we = 1; ex_is_load = 1; ex_is_store = 0; id_rs1 = 14; id_use_rs1 = 1;
        expect_out(2'b10, 2'b00, 1'b0, 1'b1, "R1 R6 same cycle");
        // Concurrent: store-data bypass while a new stall begins
        next_cycle(); ex_is_store = 1; ex_rs2 = 15;
        expect_out(2'b00, 2'b00, 1'b0, 1'b0, "R8 store before stall");
        next_cycle(); mwb_rd = 15; mwb_we = 1; mwb_is_load = 1;
        ex_rd = 16; ex_we = 1; ex_is_load = 1; id_rs2 = 16; id_use_rs2 = 1;
        expect_out(2'b00, 2'b00, 1'b1, 1'b1, "R8 R6 same cycle");

        next_cycle();
        next_cycle();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule